// File: doc/BRIEF.md
# Live-value-table multi-ported memory

This block is a storage array with several write ports and several read ports that all work in the same clock cycle, at any addresses, without stalls or arbitration. Bulk storage sits in plain RAM banks with one writer and one reader each. Every write port has its own group of banks, so two writers never compete for a bank.

A narrow register table holds one entry per address. Each entry records which write port last stored that address. On a read, the entry for the read address chooses which bank's data reaches the output. The banks together then act like one memory with true multiple ports. Each table entry holds only a port number of ceil(log2(write ports)) bits. Because of that, the table is cheap enough to build from flip-flops, and the wide data words stay in inferred block RAM.

Widths, depth and port counts are parameters. The defaults are 32-bit words, 256 entries, two write ports and two read ports. Read data is registered and comes out one clock after the address is presented.

Top module: `lvt_mpram`

## Requirements
- R1: A word written on any write port at address A can be read back on every read port. Read data appears on the clock edge after the one that samples the read address.
- R2: After a write to A by port w, reads of A return that port's data until a later write to A occurs. No other port's earlier or stale copy of A is ever returned.
- R3: When several write ports write the same address in one cycle, the lowest-numbered enabled port wins. Later reads of that address return the winner's data.
- R4: Each read port uses its own address in every cycle. Two or more read ports may present the same address, and each gets the correct word.
- R5: Write ports may write different addresses in the same cycle, and all of those writes take effect.
- R6: A read of an address that is written in the same cycle returns the value held before the write. The new value is returned from the next cycle on.
- R7: Reset (`rst_n` low on a clock edge) sets every table entry to port 0. The bank contents are not changed, so after reset every address reads the last value that write port 0 stored there.
- R8: While a read address is held and no write port is enabled, the read data stays constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the steering table and the read-select registers |
| wr_en | input | NW (2) | Write enable; bit w belongs to write port w |
| wr_addr | input | NW*AW (16) | Write addresses; port w uses bits [w*AW +: AW] |
| wr_data | input | NW*DW (64) | Write data; port w uses bits [w*DW +: DW] |
| rd_addr | input | NR*AW (16) | Read addresses; port r uses bits [r*AW +: AW] |
| rd_data | output | NR*DW (64) | Registered read data; port r drives bits [r*DW +: DW] |

## Verification
A wrong table entry does not raise any error signal. It shows up at the ports as a read that returns another write port's stale copy, on the first read of that address after the bad update, which is one clock after the read address. A write lost from a bank shows the same way, but only on reads steered to that bank. For this reason the bench reads back each collision address and each reset-affected address on every read port. Random traffic is kept inside a few addresses, so table updates are checked against a reference array within a few cycles of when they happen.

// File: rtl/lvt_mpram.sv
module lvt_mpram #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  parameter int NW    = 2,
  parameter int NR    = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int SW   = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NW-1:0]      wr_en,
  input  logic [NW*AW-1:0]   wr_addr,
  input  logic [NW*DW-1:0]   wr_data,
  input  logic [NR*AW-1:0]   rd_addr,
  output logic [NR*DW-1:0]   rd_data
);

  logic [SW-1:0]         lvt [DEPTH];
  logic [NR*SW-1:0]      sel_q;
  logic [NW*NR*DW-1:0]   bank_q;

  // banks: one copy per (writer, reader) pair
  for (genvar w = 0; w < NW; w++) begin : g_wr
    for (genvar r = 0; r < NR; r++) begin : g_rd
      logic [DW-1:0] mem [DEPTH];
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (wr_en[w]) mem[wr_addr[w*AW +: AW]] <= wr_data[w*DW +: DW];
        q <= mem[rd_addr[r*AW +: AW]];
      end
      assign bank_q[(w*NR + r)*DW +: DW] = q;
    end
  end

  // steering table: lowest port applied last so it wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) lvt[i] <= '0;
    end else begin
      for (int w = NW - 1; w >= 0; w--)
        if (wr_en[w]) lvt[wr_addr[w*AW +: AW]] <= SW'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else
      for (int r = 0; r < NR; r++)
        sel_q[r*SW +: SW] <= lvt[rd_addr[r*AW +: AW]];
  end

  always_comb begin
    for (int r = 0; r < NR; r++)
      rd_data[r*DW +: DW] = bank_q[(int'(sel_q[r*SW +: SW])*NR + r)*DW +: DW];
  end

  // ---------------- assertions ----------------
  logic [NW-1:0] lower_hit;
  always_comb begin
    for (int w = 0; w < NW; w++) begin
      lower_hit[w] = 1'b0;
      for (int v = 0; v < w; v++)
        if (wr_en[v] && wr_addr[v*AW +: AW] == wr_addr[w*AW +: AW]) lower_hit[w] = 1'b1;
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_chk_w
    a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[w] && !lower_hit[w]) |=> (lvt[$past(wr_addr[w*AW +: AW])] == SW'(w)));
    for (genvar r = 0; r < NR; r++) begin : g_chk_r
      a_r2_winner_read: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[w] && !lower_hit[w]) ##1 (rd_addr[r*AW +: AW] == $past(wr_addr[w*AW +: AW]))
        |=> (rd_data[r*DW +: DW] == $past(wr_data[w*DW +: DW], 2)));
    end
  end

  for (genvar r = 0; r < NR; r++) begin : g_chk_hold
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && rd_addr[r*AW +: AW] == $past(rd_addr[r*AW +: AW]) && $past(wr_en) == '0)
      |=> $stable(rd_data[r*DW +: DW]));
  end

  a_r7_reset_sel: assert property (@(posedge clk) !rst_n |=> (sel_q == '0));

endmodule

// File: tb/lvt_mpram_bench.sv
module lvt_mpram_bench;
  localparam int CLK_P = 10;
  localparam int DW = 32, DEPTH = 256, NW = 2, NR = 2, AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0]    wr_en = '0;
  logic [NW*AW-1:0] wr_addr = '0;
  logic [NW*DW-1:0] wr_data = '0;
  logic [NR*AW-1:0] rd_addr = '0;
  logic [NR*DW-1:0] rd_data;

  logic [DW-1:0] ref_mem [DEPTH];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  lvt_mpram #(.DW(DW), .DEPTH(DEPTH), .NW(NW), .NR(NR)) u_lvt_mpram (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  function automatic logic [DW-1:0] fillv(int a);
    return 32'hA500_0000 ^ (a * 32'h0101_0103);
  endfunction

  task automatic chk(string req, int p, logic [DW-1:0] exp);
    n_chk++;
    if (rd_data[p*DW +: DW] !== exp) begin
      n_bad++;
      $display("FAIL %s port %0d: actual %h expected %h", req, p, rd_data[p*DW +: DW], exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic setw(int p, bit en, int a, logic [DW-1:0] d);
    wr_en[p] = en; wr_addr[p*AW +: AW] = AW'(a); wr_data[p*DW +: DW] = d;
  endtask

  task automatic setr(int p, int a);
    rd_addr[p*AW +: AW] = AW'(a);
  endtask

  task automatic nowr();
    wr_en = '0;
  endtask

  // R1: fill through port 0, read back through every read port
  task automatic t_fill();
    for (int a = 0; a < DEPTH; a++) begin
      setw(0, 1, a, fillv(a)); step(); ref_mem[a] = fillv(a);
    end
    nowr();
    for (int a = 0; a < DEPTH; a += 37) begin
      setr(0, a); setr(1, DEPTH - 1 - a); step();
      chk("R1", 0, ref_mem[a]); chk("R1", 1, ref_mem[DEPTH-1-a]);
    end
  endtask

  // R2 then R7: port 1 write steers reads; reset steers back to port 0 copy
  task automatic t_reset_steer();
    setw(1, 1, 5, 32'hBEEF_0005); step(); nowr(); ref_mem[5] = 32'hBEEF_0005;
    setr(0, 5); setr(1, 5); step();
    chk("R2", 0, 32'hBEEF_0005); chk("R2", 1, 32'hBEEF_0005);
    rst_n = 1'b0; step(); rst_n = 1'b1;
    step();
    chk("R7", 0, fillv(5)); chk("R7", 1, fillv(5));
    ref_mem[5] = fillv(5);
  endtask

  // R3: both writers hit one address
  task automatic t_collide();
    setw(0, 1, 20, 32'h0000_C0DE); setw(1, 1, 20, 32'h1111_DEAD); step(); nowr();
    ref_mem[20] = 32'h0000_C0DE;
    setr(0, 20); setr(1, 20); step();
    chk("R3", 0, 32'h0000_C0DE); chk("R3", 1, 32'h0000_C0DE);
  endtask

  // R4, R5: different write addresses, crossed reads
  task automatic t_multi();
    setw(0, 1, 30, 32'h3030_0000); setw(1, 1, 31, 32'h3131_1111); step(); nowr();
    ref_mem[30] = 32'h3030_0000; ref_mem[31] = 32'h3131_1111;
    setr(0, 31); setr(1, 30); step();
    chk("R5", 0, ref_mem[31]); chk("R5", 1, ref_mem[30]);
    setr(0, 30); setr(1, 30); step();
    chk("R4", 0, ref_mem[30]); chk("R4", 1, ref_mem[30]);
  endtask

  // R6: same-cycle read returns old word, new word next cycle
  task automatic t_same_cycle();
    logic [DW-1:0] old = ref_mem[40];
    setr(0, 40); setr(1, 40); setw(1, 1, 40, 32'h4040_ABCD); step(); nowr();
    chk("R6", 0, old); chk("R6", 1, old);
    ref_mem[40] = 32'h4040_ABCD;
    step();
    chk("R6", 0, ref_mem[40]); chk("R6", 1, ref_mem[40]);
  endtask

  // R8: held address, no writes
  task automatic t_hold();
    setr(0, 31); setr(1, 20); step();
    for (int i = 0; i < 3; i++) begin
      step(); chk("R8", 0, ref_mem[31]); chk("R8", 1, ref_mem[20]);
    end
  endtask

  // R2/R3/R4/R6: random traffic on eight addresses against reference
  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      int ra0 = $urandom_range(7), ra1 = $urandom_range(7);
      int wa0 = $urandom_range(7), wa1 = $urandom_range(7);
      bit e0 = 1'($urandom), e1 = 1'($urandom);
      logic [DW-1:0] d0 = $urandom, d1 = $urandom;
      logic [DW-1:0] x0 = ref_mem[ra0], x1 = ref_mem[ra1];
      setr(0, ra0); setr(1, ra1); setw(0, e0, wa0, d0); setw(1, e1, wa1, d1);
      step();
      chk("R2", 0, x0); chk("R3", 1, x1);
      if (e1) ref_mem[wa1] = d1;
      if (e0) ref_mem[wa0] = d0;
    end
    nowr();
  endtask

  initial begin
    setr(0, 0); setr(1, 0);
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_fill();
    t_reset_steer();
    t_collide();
    t_multi();
    t_same_cycle();
    t_hold();
    t_random();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule